// File: doc/BRIEF.md
# Valley-Switching Gate Timing Controller

This block produces the gate drive for the power switch of a quasi-resonant flyback converter. Its inputs are already-digitised comparator flags. Each switching period starts with a turn-on edge. While the gate is high, a current-sense trip ends the on-time, but only after a short leading-edge mask. A maximum on-time timer ends it if no trip comes. Turn-off is followed by a blanking interval, counted from the turn-on edge, during which the switch may not turn on again.

When blanking ends, a bounded search window opens. During the window the controller watches a hysteretic pair of sync flags taken from the auxiliary winding. A valley is a fall below the low threshold that follows a rise above the high threshold. The first valley found in the window starts a fixed, parameterised delay, and the switch turns on when that delay ends. If the window closes with no valley, the switch is forced on. The switching period therefore always lies between a minimum and a maximum value.

All times are parameters counted in clock cycles. The enable input stops switching at once and returns the controller to idle. The next enable starts a pulse without any blanking.

Top module: `vsw_gate_ctrl`

## Requirements
- R1: While reset is asserted, gate_o is low and state_o reads 0 (idle).
- R2: When the controller is idle and en_i is high at a clock edge, gate_o rises at that edge and state_o reads 1 (on). No blanking interval is applied first.
- R3: The gate stays high for at most TON_MAX_CYC cycles. With no current-sense trip, the on-time is exactly TON_MAX_CYC cycles.
- R4: Cycles are numbered from the turn-on edge, starting at 0. cs_trip_i has no effect in cycles 0 to LEB_CYC-1. A trip seen in cycle k ≥ LEB_CYC makes the on-time k+1 cycles, so a trip held from turn-on gives LEB_CYC+1 cycles.
- R5: A turn-on never follows the previous one by BLANK_CYC cycles or fewer. A valley that occurs during blanking is not acted on, and it uses up the arming.
- R6: If no valley occurs in the window (cycles BLANK_CYC to BLANK_CYC+WIN_CYC-1), the next turn-on comes exactly BLANK_CYC+WIN_CYC cycles after the previous one.
- R7: If the first valley in the window occurs in cycle k, the next turn-on comes k+1+SYNC_DLY_CYC cycles after the previous one. This also holds when k is the last cycle of the window. While the delay runs, state_o reads 4.
- R8: A valley counts only when sync_lo_i is seen after a sync_hi_i that came after the current turn-off and after any earlier sync_lo_i. A sync_hi_i seen while the gate is high does not arm. A low level with no high before it never turns the switch on.
- R9: When en_i is low, gate_o is low in the same cycle, and state_o reads 0 after the next clock edge.
- R10: state_o encodes the phase as 0 idle, 1 on, 2 blanking with the gate off, 3 valley search, and 4 sync delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| en_i | input | 1 | Switching enable |
| sync_hi_i | input | 1 | Sync signal is above the high threshold |
| sync_lo_i | input | 1 | Sync signal is below the low threshold |
| cs_trip_i | input | 1 | Current-sense comparator has tripped |
| gate_o | output | 1 | Power switch gate command |
| state_o | output | 3 | Current phase (R10 encoding) |

## Verification
The bench builds the controller with blanking 40, window 12, leading-edge mask 4, maximum on-time 25 and sync delay 3 cycles. These values keep a full period near 50 cycles. A single run can then cover every window position, from the first valley cycle to the last, and reach the forced turn-on as well. Because the on-time limit is shorter than blanking, the bench can place sync edges during the on-time, during the off part of blanking and inside the window. This brings the arming rule, the disarming by valleys that fall in blanking, and the priority of a last-cycle valley over forced turn-on all within reach of directed tests.

// File: rtl/vsw_pkg.sv
package vsw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ON     = 3'd1,
    ST_BLANK  = 3'd2,
    ST_SEARCH = 3'd3,
    ST_DELAY  = 3'd4
  } vsw_state_e;
endpackage

// File: rtl/vsw_rst_sync.sv
module vsw_rst_sync (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/vsw_period_ctr.sv
module vsw_period_ctr #(
  parameter int CW  = 11,
  parameter int MAX = 1800
) (
  input  logic          clk_i,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] CNT_TOP = CW'(MAX);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)                         cnt_d = '0;
    else if (inc_i && cnt_q != CNT_TOP) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/vsw_valley_det.sv
module vsw_valley_det (
  input  logic clk_i,
  input  logic rst_n,
  input  logic active_i,
  input  logic sync_hi_i,
  input  logic sync_lo_i,
  output logic valley_o
);
  logic armed_q, armed_d;

  always_comb begin
    armed_d = armed_q;
    if (!active_i)      armed_d = 1'b0;
    else if (sync_hi_i) armed_d = 1'b1;
    else if (sync_lo_i) armed_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

  assign valley_o = armed_q & sync_lo_i & ~sync_hi_i;

  // a valley in the cycle after an inactive cycle would need an old arming
  assert_no_stale_arm_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
    !active_i |=> !valley_o);
endmodule

// File: rtl/vsw_sync_delay.sv
module vsw_sync_delay #(
  parameter int DLY = 30
) (
  input  logic clk_i,
  input  logic rst_n,
  input  logic run_i,
  output logic done_o
);
  generate
    if (DLY == 0) begin : g_none
      assign done_o = run_i;
    end else begin : g_count
      localparam int DW = (DLY > 1) ? $clog2(DLY) : 1;
      localparam logic [DW-1:0] LAST = DW'(DLY - 1);
      logic [DW-1:0] cnt_q, cnt_d;

      always_comb begin
        cnt_d = '0;
        if (run_i && cnt_q != LAST) cnt_d = cnt_q + 1'b1;
      end

      always_ff @(posedge clk_i or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      assign done_o = run_i && (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/vsw_gate_ctrl.sv
module vsw_gate_ctrl
  import vsw_pkg::*;
#(
  parameter int BLANK_CYC    = 1500,
  parameter int WIN_CYC      = 300,
  parameter int LEB_CYC      = 20,
  parameter int TON_MAX_CYC  = 1200,
  parameter int SYNC_DLY_CYC = 30
) (
  input  logic       clk_i,
  input  logic       rst_n_i,
  input  logic       en_i,
  input  logic       sync_hi_i,
  input  logic       sync_lo_i,
  input  logic       cs_trip_i,
  output logic       gate_o,
  output logic [2:0] state_o
);
  localparam int PER_MAX = BLANK_CYC + WIN_CYC;
  localparam int CW      = $clog2(PER_MAX + 1);
  localparam logic [CW-1:0] TON_LAST   = CW'(TON_MAX_CYC - 1);
  localparam logic [CW-1:0] LEB_END    = CW'(LEB_CYC);
  localparam logic [CW-1:0] BLANK_LAST = CW'(BLANK_CYC - 1);
  localparam logic [CW-1:0] WIN_LAST   = CW'(PER_MAX - 1);

  logic          rst_n;
  vsw_state_e    state_q, state_d;
  logic          gate_q, gate_d;
  logic          turn_on;
  logic [CW-1:0] per_cnt;
  logic          valley;
  logic          dly_done;
  logic          det_active;

  vsw_rst_sync u_rst_sync (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .rst_n_o (rst_n)
  );

  vsw_period_ctr #(.CW(CW), .MAX(PER_MAX)) u_period_ctr (
    .clk_i (clk_i),
    .rst_n (rst_n),
    .clr_i (turn_on),
    .inc_i (state_q != ST_IDLE),
    .cnt_o (per_cnt)
  );

  assign det_active = (state_q == ST_BLANK) || (state_q == ST_SEARCH);

  vsw_valley_det u_valley_det (
    .clk_i     (clk_i),
    .rst_n     (rst_n),
    .active_i  (det_active),
    .sync_hi_i (sync_hi_i),
    .sync_lo_i (sync_lo_i),
    .valley_o  (valley)
  );

  vsw_sync_delay #(.DLY(SYNC_DLY_CYC)) u_sync_delay (
    .clk_i  (clk_i),
    .rst_n  (rst_n),
    .run_i  (state_q == ST_DELAY),
    .done_o (dly_done)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    turn_on = 1'b0;
    if (!en_i) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          state_d = ST_ON;
          turn_on = 1'b1;
        end
        ST_ON: begin
          if (per_cnt >= TON_LAST || (cs_trip_i && per_cnt >= LEB_END))
            state_d = ST_BLANK;
        end
        ST_BLANK: begin
          if (per_cnt >= BLANK_LAST) state_d = ST_SEARCH;
        end
        ST_SEARCH: begin
          if (valley) begin
            if (SYNC_DLY_CYC == 0) begin
              state_d = ST_ON;
              turn_on = 1'b1;
            end else begin
              state_d = ST_DELAY;
            end
          end else if (per_cnt >= WIN_LAST) begin
            state_d = ST_ON;
            turn_on = 1'b1;
          end
        end
        ST_DELAY: begin
          if (dly_done) begin
            state_d = ST_ON;
            turn_on = 1'b1;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
    gate_d = (state_d == ST_ON);
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      gate_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      gate_q  <= gate_d;
    end
  end

  assign gate_o  = gate_q & en_i;
  assign state_o = state_q;

  // checker bookkeeping: cycles high so far, cycles since last turn-on
  localparam int GW = $clog2(PER_MAX + SYNC_DLY_CYC + 2) + 1;
  logic [CW:0]   chk_on_q;
  logic [GW-1:0] chk_gap_q;
  logic          chk_gate_dly_q;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      chk_on_q       <= '0;
      chk_gap_q      <= '0;
      chk_gate_dly_q <= 1'b0;
    end else begin
      chk_gate_dly_q <= gate_q;
      if (!gate_q)            chk_on_q <= '0;
      else if (~&chk_on_q)    chk_on_q <= chk_on_q + 1'b1;
      if (gate_q && !chk_gate_dly_q) chk_gap_q <= GW'(1);
      else if (~&chk_gap_q)          chk_gap_q <= chk_gap_q + 1'b1;
    end
  end

  assert_idle_start_R2: assert property (@(posedge clk_i) disable iff (!rst_n)
    (state_q == ST_IDLE && en_i) |=> gate_q);

  assert_max_on_R3: assert property (@(posedge clk_i) disable iff (!rst_n)
    chk_on_q <= (CW+1)'(TON_MAX_CYC));

  assert_leb_min_on_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    (state_q == ST_BLANK && $past(state_q) == ST_ON)
      |-> chk_on_q >= (CW+1)'(LEB_CYC + 1));

  assert_blank_gap_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    (state_q == ST_ON && $past(state_q) != ST_ON && $past(state_q) != ST_IDLE)
      |-> chk_gap_q > GW'(BLANK_CYC));

  assert_period_cap_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (state_q == ST_ON && $past(state_q) != ST_ON && $past(state_q) != ST_IDLE)
      |-> chk_gap_q <= GW'(PER_MAX + SYNC_DLY_CYC));

  assert_disable_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
    !en_i |=> (state_q == ST_IDLE && !gate_q));
endmodule

// File: tb/vsw_gate_ctrl_bench.sv
module vsw_gate_ctrl_bench;
  localparam int B = 40, W = 12, L = 4, T = 25, D = 3;

  logic clk, rst_n, en, s_hi, s_lo, cs;
  logic gate;
  logic [2:0] st;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  vsw_gate_ctrl #(.BLANK_CYC(B), .WIN_CYC(W), .LEB_CYC(L),
                  .TON_MAX_CYC(T), .SYNC_DLY_CYC(D)) u_vsw_gate_ctrl (
    .clk_i(clk), .rst_n_i(rst_n), .en_i(en), .sync_hi_i(s_hi),
    .sync_lo_i(s_lo), .cs_trip_i(cs), .gate_o(gate), .state_o(st));

  initial clk = 0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  // called at the sample point where gate has just risen (cycle 0);
  // returns at the sample point of the next rise
  task automatic run_pulse(input int mode, input string req,
                           input int exp_hi, input int exp_per);
    int hi = 1, per = 0;
    bit seen_low = 0;
    for (int i = 0; i < 400; i++) begin
      if (i > 0) begin
        @(negedge clk);
        if (gate) begin
          if (seen_low) begin per = i; break; end
          hi++;
        end else seen_low = 1;
      end
      if (mode == 0) begin
        if (i == 0)  chk("R10 on code", st, 1);
        if (i == 24) chk("R10 on code late", st, 1);
        if (i == 25) chk("R10 blank code", st, 2);
        if (i == 39) chk("R10 blank code late", st, 2);
        if (i == 40) chk("R10 search code", st, 3);
      end
      if (mode == 4 && i == 45) chk("R7 delay code", st, 4);
      cs = 0; s_hi = 0; s_lo = 0;
      case (mode)
        1: cs = 1;
        2: cs = (i == 2);
        3: cs = (i == 10);
        4: begin s_hi = (i == 30); s_lo = (i == 44); end
        5: begin s_hi = (i == 30); s_lo = (i == 35); end
        6: begin s_hi = (i == 30 || i == 38); s_lo = (i == 35 || i == 41); end
        7: s_lo = 1;
        8: begin s_hi = (i == 5); s_lo = (i == 42); end
        9: begin s_hi = (i == 30); s_lo = (i == 51); end
        10: begin s_hi = (i == 30); s_lo = (i == 40); end
        default: ;
      endcase
    end
    chk({req, " on-time"}, hi, exp_hi);
    chk({req, " period"}, per, exp_per);
  endtask

  task automatic t_reset();
    rst_n = 0; en = 0; s_hi = 0; s_lo = 0; cs = 0;
    repeat (3) @(negedge clk);
    chk("R1 gate in reset", gate, 0);
    chk("R1 state in reset", st, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 idle after reset", st, 0);
  endtask

  task automatic t_start();
    en = 1;
    @(negedge clk);
    chk("R2 gate at start", gate, 1);
    chk("R2 state at start", st, 1);
  endtask

  task automatic t_disable();
    repeat (5) @(negedge clk);
    chk("R9 gate high before drop", gate, 1);
    en = 0;
    #1;
    chk("R9 gate same cycle", gate, 0);
    @(negedge clk);
    chk("R9 state idle", st, 0);
    repeat (3) @(negedge clk);
    chk("R9 stays off", gate, 0);
    en = 1;
    @(negedge clk);
    chk("R2 restart no blanking", gate, 1);
    chk("R2 restart state", st, 1);
  endtask

  initial begin
    t_reset();
    t_start();
    run_pulse(0,  "R3 R6 free run",        T,     B + W);
    run_pulse(1,  "R4 trip held",          L + 1, B + W);
    run_pulse(2,  "R4 trip inside mask",   T,     B + W);
    run_pulse(3,  "R4 trip cycle 10",      11,    B + W);
    run_pulse(4,  "R7 valley cycle 44",    T,     44 + 1 + D);
    run_pulse(5,  "R5 valley in blanking", T,     B + W);
    run_pulse(6,  "R8 rearm after blank",  T,     41 + 1 + D);
    run_pulse(7,  "R8 stale low level",    T,     B + W);
    run_pulse(8,  "R8 high while on",      T,     B + W);
    run_pulse(9,  "R7 last window cycle",  T,     51 + 1 + D);
    run_pulse(10, "R7 first window cycle", T,     40 + 1 + D);
    t_disable();
    run_pulse(0,  "R3 R6 after restart",   T,     B + W);
    done = 1;
    summary();
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      summary();
    end
  end
endmodule